// File: doc/BRIEF.md
# Micro-step sequencer for an 8-bit core

This block is the sequencing engine of a small 8-bit processor core attached to a single-port synchronous RAM. Each opcode maps to a short list of micro-steps held in a computed microcode ROM addressed by the opcode and a 4-bit step index. Every micro-step names one internal transition and at most one memory request. That request is either a read-address selection or a write. The block walks the list, drives the RAM address, write-data and write-enable pins, and captures returned bytes into an 8-bit value buffer.

Memory requests sit on the boundary between two micro-steps. A step that needs a byte has its read address issued during the step before it, and the byte arrives one cycle later. A write is issued during the step that owns it. Because the RAM has one port, no boundary carries both. One memory-indirect increment instruction is implemented, addressed through an external 16-bit pair value `hl_i`. Every other opcode decodes to the padding micro-op, which starts the next fetch at once.

Top module: `useq_top`

## Requirements
- R1: After reset the block presents a fetch read at program address 0 (RESET_PC), with write-enable low and the zero flag clear.
- R2: Instruction fetches read consecutive program addresses, one higher at each fetch.
- R3: For opcode 8'h34 the operand read is presented with address equal to `hl_i` two cycles after that instruction's fetch cycle.
- R4: For opcode 8'h34 write-enable is high exactly five cycles after the fetch cycle, with address `hl_i` and data equal to the operand plus one, modulo 256.
- R5: From the cycle after an increment's write, `zero_o` is 1 if and only if the written byte is 0.
- R6: Any opcode other than 8'h34 starts the next fetch two cycles after its own fetch, causes no write, and leaves `zero_o` unchanged.
- R7: Read strobe and write-enable are never high in the same cycle.
- R8: The step index never reaches MAX_STEPS (10); every sequence ends in the padding fetch micro-op.
- R9: After opcode 8'h34 the next fetch comes exactly six cycles after its fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hl_i | input | 16 | Register-pair value used as the indirect address |
| mem_rdata_i | input | 8 | RAM read data, valid one cycle after the address |
| mem_addr_o | output | 16 | RAM address |
| mem_rd_o | output | 1 | A read address is presented this cycle |
| mem_we_o | output | 1 | Write enable |
| mem_wdata_o | output | 8 | RAM write data |
| zero_o | output | 1 | Zero flag, set from the last value written back |

## Verification
The embedded assertions watch on every cycle that read and write never coincide, that the step index stays within bounds, that each fetch advances the program counter, that written data is the value buffer plus one, and that the zero flag follows each write. The exact cycle placement of the operand read, the write and the following fetch, the addresses used, and the wrap of the stored byte through every value from 0 to 255 are shown only by the bench's instruction streams, which mix the increment opcode with other opcodes.

// File: rtl/useq_pkg.sv
package useq_pkg;

   typedef enum logic [2:0] {
      X_FETCH  = 3'd0,
      X_IDLE   = 3'd1,
      X_AB_HL  = 3'd2,
      X_VB_LD  = 3'd3,
      X_VB_INC = 3'd4,
      X_FLAGS  = 3'd5
   } xfer_t;

   typedef enum logic [1:0] {
      S_BOOT   = 2'd0,
      S_DECODE = 2'd1,
      S_EXEC   = 2'd2
   } seq_state_t;

   typedef struct packed {
      xfer_t xfer;
      logic  rd;
      logic  rd_ab;
      logic  wr;
   } uword_t;

   localparam uword_t W_FETCH  = '{xfer: X_FETCH,  rd: 1'b1, rd_ab: 1'b0, wr: 1'b0};
   localparam uword_t W_HL_RD  = '{xfer: X_AB_HL,  rd: 1'b1, rd_ab: 1'b1, wr: 1'b0};
   localparam uword_t W_LOAD   = '{xfer: X_VB_LD,  rd: 1'b0, rd_ab: 1'b0, wr: 1'b0};
   localparam uword_t W_INCR   = '{xfer: X_VB_INC, rd: 1'b0, rd_ab: 1'b0, wr: 1'b0};
   localparam uword_t W_FLG_WR = '{xfer: X_FLAGS,  rd: 1'b0, rd_ab: 1'b0, wr: 1'b1};

endpackage

// File: rtl/useq_rom.sv
module useq_rom
   import useq_pkg::*;
#(
   parameter int         OP_W      = 8,
   parameter int         STEP_W    = 4,
   parameter int         MAX_STEPS = 10,
   parameter logic [7:0] INC_OP    = 8'h34
) (
   input  logic [OP_W-1:0]   opcode,
   input  logic [STEP_W-1:0] step,
   output uword_t            word
);
   localparam int ROM_AW = OP_W + STEP_W;

   uword_t inc_prog [MAX_STEPS];

   for (genvar s = 0; s < MAX_STEPS; s++) begin : g_prog
      if (s == 0)      begin : g_s0 assign inc_prog[s] = W_HL_RD;  end
      else if (s == 1) begin : g_s1 assign inc_prog[s] = W_LOAD;   end
      else if (s == 2) begin : g_s2 assign inc_prog[s] = W_INCR;   end
      else if (s == 3) begin : g_s3 assign inc_prog[s] = W_FLG_WR; end
      else             begin : g_pad assign inc_prog[s] = W_FETCH; end
   end

   logic [ROM_AW-1:0] idx;
   assign idx = {opcode, step};

   always_comb begin
      word = W_FETCH;
      if (idx[ROM_AW-1:STEP_W] == OP_W'(INC_OP) && int'(idx[STEP_W-1:0]) < MAX_STEPS)
         word = inc_prog[idx[STEP_W-1:0]];
   end

   // R7: no ROM word asks for a read and a write on the same boundary
   always_comb begin
      p_word_excl_r7: assert (!(word.rd && word.wr));
   end
endmodule

// File: rtl/useq_dpath.sv
module useq_dpath
   import useq_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int RESET_PC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  xfer_t             xfer,
   input  logic              pc_step,
   input  logic [ADDR_W-1:0] hl,
   input  logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] ab_nxt,
   output logic [ADDR_W-1:0] pc_q,
   output logic [DATA_W-1:0] vb_q,
   output logic              zero_q
);
   logic [ADDR_W-1:0] ab_q;

   assign ab_nxt = (xfer == X_AB_HL) ? hl : ab_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ab_q   <= '0;
         pc_q   <= ADDR_W'(RESET_PC);
         vb_q   <= '0;
         zero_q <= 1'b0;
      end else begin
         ab_q <= ab_nxt;
         if (pc_step) pc_q <= pc_q + 1'b1;
         case (xfer)
            X_VB_LD:  vb_q <= rdata;
            X_VB_INC: vb_q <= vb_q + 1'b1;
            X_FLAGS:  zero_q <= (vb_q == '0);
            default:  ;
         endcase
      end
   end

   // R2: every fetch moves the program counter on by one
   p_pc_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pc_step |=> (pc_q == $past(pc_q) + 1'b1));
endmodule

// File: rtl/useq_top.sv
module useq_top
   import useq_pkg::*;
#(
   parameter int         ADDR_W    = 16,
   parameter int         DATA_W    = 8,
   parameter int         STEP_W    = 4,
   parameter int         MAX_STEPS = 10,
   parameter int         RESET_PC  = 0,
   parameter logic [7:0] INC_OP    = 8'h34
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       hl_i,
   input  logic [7:0]        mem_rdata_i,
   output logic [15:0]       mem_addr_o,
   output logic              mem_rd_o,
   output logic              mem_we_o,
   output logic [7:0]        mem_wdata_o,
   output logic              zero_o
);
   localparam int STEP_LIM = 1 << STEP_W;

   initial begin : elab_chk
      if (MAX_STEPS < 5 || MAX_STEPS >= STEP_LIM)
         $fatal(1, "MAX_STEPS must be in 5..2**STEP_W-1");
      if (ADDR_W != 16 || DATA_W != 8)
         $fatal(1, "port widths fixed at 16-bit address, 8-bit data");
   end

   seq_state_t        st_q;
   logic [DATA_W-1:0] ir_q;
   logic [STEP_W-1:0] step_q;
   uword_t            word;
   logic              exec, is_fetch, use_ab;
   xfer_t             xfer;
   logic [ADDR_W-1:0] ab_nxt, pc_q;
   logic [DATA_W-1:0] vb_q;

   useq_rom #(.OP_W(DATA_W), .STEP_W(STEP_W), .MAX_STEPS(MAX_STEPS), .INC_OP(INC_OP))
      rom_i (.opcode(ir_q), .step(step_q), .word(word));

   assign exec     = (st_q == S_EXEC);
   assign is_fetch = (st_q == S_BOOT) || (exec && word.xfer == X_FETCH);
   assign xfer     = exec ? word.xfer : X_IDLE;
   assign use_ab   = exec && ((word.rd && word.rd_ab) || word.wr);

   useq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_PC(RESET_PC))
      dp_i (.clk(clk), .rst_n(rst_n), .xfer(xfer), .pc_step(is_fetch), .hl(hl_i),
            .rdata(mem_rdata_i), .ab_nxt(ab_nxt), .pc_q(pc_q), .vb_q(vb_q),
            .zero_q(zero_o));

   assign mem_rd_o    = is_fetch || (exec && word.rd);
   assign mem_we_o    = exec && word.wr;
   assign mem_addr_o  = use_ab ? ab_nxt : pc_q;
   assign mem_wdata_o = vb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_BOOT;
         ir_q   <= '0;
         step_q <= '0;
      end else begin
         case (st_q)
            S_BOOT:   st_q <= S_DECODE;
            S_DECODE: begin
               ir_q   <= mem_rdata_i;
               step_q <= '0;
               st_q   <= S_EXEC;
            end
            default: begin
               if (is_fetch) begin
                  step_q <= '0;
                  st_q   <= S_DECODE;
               end else begin
                  step_q <= step_q + 1'b1;
               end
            end
         endcase
      end
   end

   // R7: single-port RAM never sees read and write together
   p_rd_wr_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_o && mem_we_o));

   // R8: step index stays inside the sequence length
   p_step_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      exec |-> (int'(step_q) < MAX_STEPS));

   // R4: written byte is the value buffer one step earlier, plus one
   p_wdata_incr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> (mem_wdata_o == 8'($past(vb_q) + 1'b1)));

   // R5: zero flag follows the byte just written
   p_zero_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mem_we_o) |-> (zero_o == ($past(mem_wdata_o) == 8'h00)));
endmodule

// File: tb/useq_top_tb_top.sv
`timescale 1ns/1ps
module useq_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] hl = 16'h8000;
   logic [7:0]  rdata = 8'h00;
   logic [15:0] addr;
   logic        rd, we, zero;
   logic [7:0]  wdata;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   useq_top dut_i (.clk(clk), .rst_n(rst_n), .hl_i(hl), .mem_rdata_i(rdata),
                   .mem_addr_o(addr), .mem_rd_o(rd), .mem_we_o(we),
                   .mem_wdata_o(wdata), .zero_o(zero));

   always #10 clk = ~clk;

   logic [7:0] mem [0:65535];
   always @(posedge clk) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   int  run_mode = 0, run_len = 0;
   function automatic logic [7:0] op_at(int a);
      if (a >= run_len) return 8'h00;
      if (run_mode == 1 && (a % 3) == 2) return 8'h00;
      return 8'h34;
   endfunction

   bit         mon_en = 0;
   int         cyc = 0, last_f = 0, exp_pc = 0;
   logic [7:0] shadow = 8'h00;
   bit         exp_zero = 0;

   always @(negedge clk) begin
      #2;
      if (mon_en) begin
         if (cyc == 0) begin
            chk(rd == 1'b1 && addr == 16'h0000, "R1 boot fetch", {15'd0, rd, addr}, 32'h10000);
            chk(we == 1'b0, "R1 no write", we, 0);
            chk(zero == 1'b0, "R1 zero clear", zero, 0);
         end
         chk(!(rd && we), "R7 rd/we exclusive", {rd, we}, 0);
         if (rd && addr != hl) begin
            chk(addr == 16'(exp_pc), "R2 fetch address", addr, exp_pc);
            if (exp_pc > 0) begin
               if (op_at(exp_pc - 1) == 8'h34)
                  chk(cyc - last_f == 6, "R9 increment length", cyc - last_f, 6);
               else
                  chk(cyc - last_f == 2, "R6 other opcode length", cyc - last_f, 2);
            end
            chk(zero == exp_zero, "R5/R6 zero flag at fetch", zero, exp_zero);
            last_f = cyc;
            exp_pc++;
         end else if (rd) begin
            chk(cyc - last_f == 2, "R3 operand read slot", cyc - last_f, 2);
         end
         if (we) begin
            chk(cyc - last_f == 5, "R4 write slot", cyc - last_f, 5);
            chk(addr == hl, "R4 write address", addr, hl);
            chk(wdata == 8'(shadow + 1), "R4 write data", wdata, 8'(shadow + 1));
            shadow   = 8'(shadow + 1);
            exp_zero = (shadow == 8'h00);
         end
         cyc++;
      end
   end

   task automatic run(input logic [15:0] h, input logic [7:0] v0, input int mode, input int len);
      int incs = 0;
      mon_en = 0;
      rst_n  = 0;
      for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
      run_mode = mode;
      run_len  = len;
      for (int i = 0; i < len; i++) begin
         mem[i] = op_at(i);
         if (op_at(i) == 8'h34) incs++;
      end
      hl = h;
      mem[h] = v0;
      shadow = v0;
      exp_zero = 0;
      cyc = 0; last_f = 0; exp_pc = 0;
      repeat (3) @(negedge clk);
      rst_n  = 1;
      mon_en = 1;
      wait (exp_pc > len);
      repeat (4) @(negedge clk);
      mon_en = 0;
      chk(mem[h] == 8'(v0 + incs), "R4 final stored byte", mem[h], 8'(v0 + incs));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // every stored value 0..255 passes through, including the wrap to zero (R5)
      run(16'h8000, 8'h00, 0, 300);
      // mixed stream with other opcodes (R6), wrap near top of address space
      run(16'hFFFF, 8'hFD, 1, 30);
      finish_run();
   end
endmodule